// File: doc/BRIEF.md
# Speculative Load Tracking Queue

This block keeps the bookkeeping for loads that were allowed to read the cache early, while an older load or store was still outstanding. Each such load takes a slot in a small circular queue. The slot holds the cache-line address the load read and a poisoned flag. The block watches the cache's coherence-invalidation and eviction notices. A notice that hits a tracked line poisons every slot holding that line.

When the core reports that all accesses older than the oldest tracked load have completed, the block resolves that oldest slot. A clean slot commits and its value is kept. A poisoned slot is squashed together with every younger slot, and the core is told to replay from that slot. Stores never enter the queue. Re-executing loads is left to the surrounding pipeline.

Top module: `spec_load_queue`

## Requirements
- R1: A load with `ld_valid` high is recorded at slot `ld_slot` when `ld_ready` is high and either `ld_behind_older` is high or the queue already holds an entry. A load with `ld_behind_older` low that arrives at an empty queue is not recorded.
- R2: The queue holds at most DEPTH entries. `ld_ready` is low whenever it is full, and a load offered then is not recorded.
- R3: Addresses are compared by cache line. Two addresses match when they agree in every bit above the low log2(LINE_BYTES) bits (6 bits for 64-byte lines).
- R4: An `inv_valid` notice whose line matches a tracked entry poisons that entry.
- R5: An `evict_valid` notice whose line matches a tracked entry poisons that entry, exactly as an invalidation does.
- R6: `older_done` with a non-empty queue and a clean oldest entry raises `commit_valid` in the same cycle, with `commit_slot` equal to that entry's slot, and removes the entry. `commit_valid` and `replay_valid` are never high together.
- R7: `older_done` with a poisoned oldest entry raises `replay_valid` in the same cycle, with `replay_slot` equal to that entry's slot and `replay_count` equal to the number of entries held. All entries are then discarded.
- R8: Entries resolve strictly from the oldest. A poisoned younger entry does not stop an older clean entry from committing, and slots are handed out in increasing order modulo DEPTH.
- R9: A notice that arrives in the same cycle as `older_done` counts against the oldest entry. A notice that arrives in the same cycle as a recorded load poisons that new entry when the lines match.
- R10: In a squash cycle `ld_ready` is low and the offered load is not recorded.
- R11: `older_done` with an empty queue has no effect and raises neither `commit_valid` nor `replay_valid`.
- R12: After reset the queue is empty, `ld_ready` is high, `ld_slot` is 0 and neither outcome is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_valid | input | 1 | A load is issuing this cycle |
| ld_addr | input | ADDR_W | Byte address read by the issuing load |
| ld_behind_older | input | 1 | An older load or store is still pending |
| ld_ready | output | 1 | Queue can accept a load this cycle |
| ld_slot | output | log2(DEPTH) | Slot given to a load recorded this cycle |
| inv_valid | input | 1 | Invalidation notice from another processor |
| inv_addr | input | ADDR_W | Address of the invalidated line |
| evict_valid | input | 1 | Eviction notice from the local cache |
| evict_addr | input | ADDR_W | Address of the evicted line |
| older_done | input | 1 | All accesses older than the oldest entry completed |
| commit_valid | output | 1 | Oldest entry confirmed this cycle |
| commit_slot | output | log2(DEPTH) | Slot of the confirmed entry |
| replay_valid | output | 1 | Oldest entry and all younger ones squashed |
| replay_slot | output | log2(DEPTH) | Slot of the oldest squashed entry |
| replay_count | output | log2(DEPTH+1) | Number of entries squashed |

## Verification
The bench builds the queue with DEPTH set to 4 and the default 64-byte line and 32-bit address. The shallow queue fills within a few issues, so the full stall, pointer wrap-around and full-queue squashes happen often. Load and notice addresses come from six lines with random offsets within each line. This makes line matches that differ only in the low bits common, as are notices that coincide with a resolve or an issue.

// File: rtl/slq_pkg.sv
package slq_pkg;

   // Outcome of resolving the oldest queue entry in a cycle
   typedef enum logic [1:0] {
      RES_IDLE   = 2'd0,
      RES_COMMIT = 2'd1,
      RES_SQUASH = 2'd2
   } slq_res_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/slq_line_cmp.sv
module slq_line_cmp #(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned LINE_W = 26
) (
   input  logic [DEPTH-1:0][LINE_W-1:0] entry_line,
   input  logic [LINE_W-1:0]            new_line,
   input  logic                         inv_v,
   input  logic [LINE_W-1:0]            inv_line,
   input  logic                         ev_v,
   input  logic [LINE_W-1:0]            ev_line,
   output logic [DEPTH-1:0]             entry_hit,
   output logic                         new_hit
);

   localparam int unsigned SPAN = ADDR_W - LINE_W;

   generate
      if (SPAN == 0 || LINE_W == 0) begin : g_bad_split
         $error("slq_line_cmp: line field must be narrower than the address");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < DEPTH; gi++) begin : g_entry
         assign entry_hit[gi] = (inv_v && (entry_line[gi] == inv_line)) ||
                                (ev_v  && (entry_line[gi] == ev_line));
      end
   endgenerate

   assign new_hit = (inv_v && (new_line == inv_line)) ||
                    (ev_v  && (new_line == ev_line));

endmodule

// File: rtl/slq_ring_ctrl.sv
module slq_ring_ctrl #(
   parameter int unsigned DEPTH = 8,
   localparam int unsigned PTR_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic             flush,
   output logic [PTR_W-1:0] head,
   output logic [PTR_W-1:0] tail,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty
);

   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

   generate
      if (!slq_pkg::is_pow2(DEPTH) || DEPTH < 2) begin : g_bad_depth
         $error("slq_ring_ctrl: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [PTR_W-1:0] head_q, tail_q;
   logic [CNT_W-1:0] count_q;

   assign head  = head_q;
   assign tail  = tail_q;
   assign count = count_q;
   assign full  = (count_q == DEPTH_C);
   assign empty = (count_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q  <= '0;
         tail_q  <= '0;
         count_q <= '0;
      end else if (flush) begin
         tail_q  <= head_q;
         count_q <= '0;
      end else begin
         if (pop)  head_q <= head_q + 1'b1;
         if (push) tail_q <= tail_q + 1'b1;
         case ({push, pop})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= DEPTH_C);

   assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count_q == '0));

   assert_head_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !flush) |=> (head_q == $past(head_q) + 1'b1));

   assert_no_push_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !push);

endmodule

// File: rtl/spec_load_queue.sv
module spec_load_queue
   import slq_pkg::*;
#(
   parameter int unsigned DEPTH      = 8,
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned LINE_BYTES = 64,
   localparam int unsigned PTR_W     = $clog2(DEPTH),
   localparam int unsigned CNT_W     = $clog2(DEPTH + 1),
   localparam int unsigned OFS_W     = $clog2(LINE_BYTES),
   localparam int unsigned LINE_W    = ADDR_W - OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_valid,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic              ld_behind_older,
   output logic              ld_ready,
   output logic [PTR_W-1:0]  ld_slot,
   input  logic              inv_valid,
   input  logic [ADDR_W-1:0] inv_addr,
   input  logic              evict_valid,
   input  logic [ADDR_W-1:0] evict_addr,
   input  logic              older_done,
   output logic              commit_valid,
   output logic [PTR_W-1:0]  commit_slot,
   output logic              replay_valid,
   output logic [PTR_W-1:0]  replay_slot,
   output logic [CNT_W-1:0]  replay_count
);

   generate
      if (!is_pow2(LINE_BYTES) || LINE_BYTES < 2) begin : g_bad_line
         $error("spec_load_queue: LINE_BYTES must be a power of two");
      end
      if (ADDR_W <= OFS_W) begin : g_bad_addr
         $error("spec_load_queue: address narrower than line offset");
      end
   endgenerate

   // ---------------- entry storage ----------------
   logic [DEPTH-1:0][LINE_W-1:0] line_q;
   logic [DEPTH-1:0]             poison_q;

   // ---------------- ring pointers ----------------
   logic [PTR_W-1:0] head, tail;
   logic [CNT_W-1:0] count;
   logic             full, empty;
   logic             push, pop, flush;

   // ---------------- line match ----------------
   logic [LINE_W-1:0] new_line, inv_line, ev_line;
   logic [DEPTH-1:0]  entry_hit;
   logic              new_hit;

   assign new_line = ld_addr[ADDR_W-1:OFS_W];
   assign inv_line = inv_addr[ADDR_W-1:OFS_W];
   assign ev_line  = evict_addr[ADDR_W-1:OFS_W];

   slq_line_cmp #(
      .DEPTH  (DEPTH),
      .ADDR_W (ADDR_W),
      .LINE_W (LINE_W)
   ) u_cmp (
      .entry_line (line_q),
      .new_line   (new_line),
      .inv_v      (inv_valid),
      .inv_line   (inv_line),
      .ev_v       (evict_valid),
      .ev_line    (ev_line),
      .entry_hit  (entry_hit),
      .new_hit    (new_hit)
   );

   // ---------------- resolution of the oldest entry ----------------
   slq_res_e res;
   logic     head_bad;

   assign head_bad = poison_q[head] | entry_hit[head];

   always_comb begin
      res = RES_IDLE;
      if (older_done && !empty) begin
         res = head_bad ? RES_SQUASH : RES_COMMIT;
      end
   end

   assign pop   = (res == RES_COMMIT);
   assign flush = (res == RES_SQUASH);

   assign ld_ready = !full && !flush;
   assign push     = ld_valid && ld_ready && (ld_behind_older || !empty);
   assign ld_slot  = tail;

   assign commit_valid = pop;
   assign commit_slot  = head;
   assign replay_valid = flush;
   assign replay_slot  = head;
   assign replay_count = count;

   slq_ring_ctrl #(
      .DEPTH (DEPTH)
   ) u_ring (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .pop   (pop),
      .flush (flush),
      .head  (head),
      .tail  (tail),
      .count (count),
      .full  (full),
      .empty (empty)
   );

   // ---------------- per-entry state ----------------
   genvar gi;
   generate
      for (gi = 0; gi < DEPTH; gi++) begin : g_slot
         logic alloc;
         assign alloc = push && (tail == PTR_W'(gi));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               line_q[gi]   <= '0;
               poison_q[gi] <= 1'b0;
            end else if (alloc) begin
               line_q[gi]   <= new_line;
               poison_q[gi] <= new_hit;
            end else begin
               poison_q[gi] <= poison_q[gi] | entry_hit[gi];
            end
         end
      end
   endgenerate

   // ---------------- checks on the outcome ports ----------------
   assert_one_outcome_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({commit_valid, replay_valid}));

   assert_empty_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0) |-> (!commit_valid && !replay_valid));

   assert_squash_stalls_R10: assert property (@(posedge clk) disable iff (!rst_n)
      replay_valid |-> !ld_ready);

   assert_full_stalls_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CNT_W'(DEPTH)) |-> !ld_ready);

   assert_replay_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
      replay_valid |-> (replay_count != '0));

endmodule

// File: tb/spec_load_queue_tb_top.sv
module spec_load_queue_tb_top;

   localparam int DEPTH  = 4;
   localparam int ADDR_W = 32;
   localparam int PTR_W  = $clog2(DEPTH);
   localparam int CNT_W  = $clog2(DEPTH + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;   // 200 MHz

   logic              ld_valid = 0, ld_behind_older = 0;
   logic [ADDR_W-1:0] ld_addr = '0, inv_addr = '0, evict_addr = '0;
   logic              inv_valid = 0, evict_valid = 0, older_done = 0;
   logic              ld_ready, commit_valid, replay_valid;
   logic [PTR_W-1:0]  ld_slot, commit_slot, replay_slot;
   logic [CNT_W-1:0]  replay_count;

   spec_load_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LINE_BYTES(64)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_behind_older(ld_behind_older),
      .ld_ready(ld_ready), .ld_slot(ld_slot),
      .inv_valid(inv_valid), .inv_addr(inv_addr),
      .evict_valid(evict_valid), .evict_addr(evict_addr),
      .older_done(older_done),
      .commit_valid(commit_valid), .commit_slot(commit_slot),
      .replay_valid(replay_valid), .replay_slot(replay_slot),
      .replay_count(replay_count)
   );

   int checks = 0;
   int errors = 0;

   // reference model state
   int m_head = 0, m_cnt = 0;
   int m_line [DEPTH];
   bit m_pois [DEPTH];

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic bit hits(input int line);
      return (inv_valid && (int'(inv_addr >> 6) == line)) ||
             (evict_valid && (int'(evict_addr >> 6) == line));
   endfunction

   // One cycle: drive at negedge, compare, advance the model, wait for posedge.
   task automatic cyc(input bit lv, input int la, input bit lb,
                      input bit iv, input int ia, input bit ev, input int ea,
                      input bit od);
      bit squash, commit, ready, accept;
      int tail;
      @(negedge clk);
      ld_valid = lv; ld_addr = la; ld_behind_older = lb;
      inv_valid = iv; inv_addr = ia; evict_valid = ev; evict_addr = ea;
      older_done = od;
      #1;
      squash = od && m_cnt > 0 && (m_pois[m_head] || hits(m_line[m_head]));
      commit = od && m_cnt > 0 && !squash;
      ready  = (m_cnt < DEPTH) && !squash;
      tail   = (m_head + m_cnt) % DEPTH;
      accept = lv && ready && (lb || m_cnt > 0);
      chk("R2/R10", "ld_ready", int'(ld_ready), int'(ready));
      chk("R1", "ld_slot", int'(ld_slot), tail);
      chk("R6", "commit_valid", int'(commit_valid), int'(commit));
      chk("R7", "replay_valid", int'(replay_valid), int'(squash));
      if (commit) chk("R8", "commit_slot", int'(commit_slot), m_head);
      if (squash) begin
         chk("R7", "replay_slot", int'(replay_slot), m_head);
         chk("R7", "replay_count", int'(replay_count), m_cnt);
      end
      // model next state
      for (int i = 0; i < DEPTH; i++) if (hits(m_line[i])) m_pois[i] = 1'b1;
      if (squash) m_cnt = 0;
      else if (commit) begin m_head = (m_head + 1) % DEPTH; m_cnt--; end
      if (accept) begin
         m_line[tail] = la >> 6;
         m_pois[tail] = hits(la >> 6);
         m_cnt++;
      end
      @(posedge clk);
   endtask

   task automatic idle();
      cyc(0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      #(5ns * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) begin m_line[i] = 0; m_pois[i] = 0; end
      repeat (3) @(posedge clk);
      // R12: reset values
      #1;
      chk("R12", "ld_ready in reset", int'(ld_ready), 1);
      chk("R12", "ld_slot in reset", int'(ld_slot), 0);
      chk("R12", "commit in reset", int'(commit_valid), 0);
      @(negedge clk); rst_n = 1'b1;
      idle();

      // R1: non-speculative load into empty queue is not recorded; R11 resolve on empty
      cyc(1, 'h1000, 0, 0, 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 0, 0, 0, 1);
      // R6/R8: two clean loads commit in order
      cyc(1, 'h1000, 1, 0, 0, 0, 0, 0);
      cyc(1, 'h2040, 0, 0, 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 0, 0, 0, 1);
      cyc(0, 0, 0, 0, 0, 0, 0, 1);
      // R3/R4: invalidate at a different offset of same line poisons
      cyc(1, 'h3004, 1, 0, 0, 0, 0, 0);
      cyc(1, 'h4000, 0, 0, 0, 0, 0, 0);
      cyc(0, 0, 0, 1, 'h303C, 0, 0, 0);
      cyc(0, 0, 0, 0, 0, 0, 0, 1);
      // R5 eviction poisons; R8 younger poisoned, older clean commits first
      cyc(1, 'h5000, 1, 0, 0, 0, 0, 0);
      cyc(1, 'h6000, 1, 0, 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 0, 1, 'h6020, 0);
      cyc(0, 0, 0, 0, 0, 0, 0, 1);
      cyc(0, 0, 0, 0, 0, 0, 0, 1);
      // R2: fill to DEPTH, extra load refused; R10 load during squash refused
      for (int i = 0; i < DEPTH + 1; i++) cyc(1, 'h7000 + i * 64, 1, 0, 0, 0, 0, 0);
      cyc(0, 0, 0, 1, 'h7000, 0, 0, 0);
      cyc(1, 'h8000, 1, 0, 0, 0, 0, 1);
      // R9: notice with resolve, and notice with issue
      cyc(1, 'h9000, 1, 0, 0, 0, 0, 0);
      cyc(0, 0, 0, 1, 'h9010, 0, 0, 1);
      cyc(1, 'hA000, 1, 0, 0, 1, 'hA008, 0);
      cyc(0, 0, 0, 0, 0, 0, 0, 1);
      // line boundary: next line must not match (R3)
      cyc(1, 'hB03F, 1, 0, 0, 0, 0, 0);
      cyc(0, 0, 0, 1, 'hB040, 0, 0, 1);

      // random traffic over six lines
      for (int n = 0; n < 4000; n++) begin
         cyc(($urandom % 2) == 0, (($urandom % 6) << 6) | ($urandom % 64), ($urandom % 2) == 0,
             ($urandom % 7) == 0, (($urandom % 6) << 6) | ($urandom % 64),
             ($urandom % 10) == 0, (($urandom % 6) << 6) | ($urandom % 64),
             ($urandom % 3) == 0);
      end
      idle();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule